// File: doc/BRIEF.md
# SPI Serial Nonvolatile RAM Target

This block is the target side of a serial magnetic RAM: an SPI slave in mode 0 that fronts a byte-wide on-chip array. A host lowers chip select, shifts in a one-byte command and, for array access, a three-byte address. Data then streams in either direction, one byte per eight clocks, for as long as select stays low. There is no erase step and no alignment rule: any byte at any address may be written directly.

Array writes and status writes are gated by a write-enable latch. A dedicated one-byte frame arms the latch. The latch disarms itself when a data-write frame or a status-write frame ends. A small status register holds a status-lock bit, two region-guard bits that fence off part of the array, and the latch. The serial pins are brought into the system clock domain through synchronizers. All decode runs on the system clock, so the serial clock must be slow against it: a half period of at least eight system clocks.

The array depth is `2**ADDR_BITS` bytes. The production setting is 19 bits (512 KiB). The default is smaller so that the model stays light.

Top module: `mram_spi_target`

## Requirements
- R1: After reset the status byte reads 0x00 and `spi_miso` is low; `spi_miso` stays low whenever select is high; reset does not alter array contents.
- R2: Command codes are 0x06 arm latch, 0x04 disarm latch, 0x05 read status, 0x01 write status, 0x03 read array, 0x02 write array.
- R3: Bits move MSB first; MOSI is taken on the rising serial clock edge, and MISO changes only on falling edges, so each reply bit is valid before the rising edge that the host samples it on.
- R4: Read and write commands take three address bytes, most significant byte first; only the low `ADDR_BITS` bits are used; a read then returns array bytes for every further byte clocked.
- R5: The array address steps by one after every data byte, read or write, and wraps from `2**ADDR_BITS-1` to 0.
- R6: Command 0x06 sets the latch (status bit 1); command 0x04 clears it.
- R7: Data bytes of a write frame are stored only while the latch is set; otherwise the array is left unchanged.
- R8: The latch clears when select rises at the end of a write-array or write-status frame.
- R9: Write status copies bits 7, 3 and 2 of its first data byte into the status register only when the latch is set and status bit 7 (lock) is clear; the other bits read 0; once the lock is set, the status register cannot be changed until reset.
- R10: Guard bits 3:2 fence off part of the array: 00 none, 01 top quarter, 10 top half, 11 all; a fenced byte is not written, but the address still steps.
- R11: Read status returns the status byte for every byte clocked; an unknown command makes the rest of its frame ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, idles low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |

## Verification
A serial edge reaches the decode logic three system clocks after the pin moves: two synchronizer flops and one edge register. A reply bit therefore appears on `spi_miso` about four clocks after a falling edge. An array write lands about four clocks after the eighth rising edge of its byte. Status changes show in the next frame. The bench holds each serial clock level for eight system clocks and samples `spi_miso` on the last clock before each rising edge. It reads back every status and array effect in a later frame, so each result is sampled well after it is due.

// File: rtl/mspi_pkg.sv
package mspi_pkg;
  localparam logic [7:0] OP_ARM     = 8'h06;
  localparam logic [7:0] OP_DISARM  = 8'h04;
  localparam logic [7:0] OP_STAT_RD = 8'h05;
  localparam logic [7:0] OP_STAT_WR = 8'h01;
  localparam logic [7:0] OP_READ    = 8'h03;
  localparam logic [7:0] OP_WRITE   = 8'h02;

  typedef enum logic [2:0] {
    PH_OPCODE, PH_ADDR, PH_RDATA, PH_WDATA, PH_STAT_RD, PH_STAT_WR, PH_SKIP
  } phase_e;

  // Guard decode: 01 top quarter, 10 top half, 11 whole array.
  function automatic logic addr_guarded(input logic [23:0] addr, input int abits,
                                        input logic [1:0] bp);
    case (bp)
      2'b00:   return 1'b0;
      2'b01:   return addr[abits-1] & addr[abits-2];
      2'b10:   return addr[abits-1];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] pack_status(input logic lock, input logic [1:0] bp,
                                             input logic wel);
    return {lock, 3'b000, bp, wel, 1'b0};
  endfunction
endpackage

// File: rtl/mspi_frontend.sv
module mspi_frontend #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_sel,
  output logic frame_end,
  output logic mosi_s
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] sclk_q, cs_q, mosi_q;
  logic         sclk_d, cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_q <= {sclk_q[TOP-1:0], sclk};
      cs_q   <= {cs_q[TOP-1:0], cs_n};
      mosi_q <= {mosi_q[TOP-1:0], mosi};
      sclk_d <= sclk_q[TOP];
      cs_d   <= cs_q[TOP];
    end
  end

  assign sclk_rise = sclk_q[TOP] & ~sclk_d;
  assign sclk_fall = ~sclk_q[TOP] & sclk_d;
  assign cs_sel    = ~cs_q[TOP];
  assign frame_end = cs_q[TOP] & ~cs_d;
  assign mosi_s    = mosi_q[TOP];
endmodule

// File: rtl/mspi_array.sv
module mspi_array #(
  parameter int ADDR_BITS = 10
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [ADDR_BITS-1:0] addr,
  input  logic [7:0]           wdata,
  output logic [7:0]           rdata
);
  localparam int DEPTH = 1 << ADDR_BITS;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
    rdata <= cells[addr];
  end
endmodule

// File: rtl/mspi_ctrl.sv
module mspi_ctrl
  import mspi_pkg::*;
#(
  parameter int ADDR_BITS = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sclk_rise,
  input  logic                 sclk_fall,
  input  logic                 cs_sel,
  input  logic                 frame_end,
  input  logic                 mosi_s,
  input  logic [7:0]           rdata,
  output logic                 we,
  output logic [ADDR_BITS-1:0] mem_addr,
  output logic [7:0]           wdata,
  output logic                 miso
);
  phase_e               phase;
  logic [2:0]           bit_cnt;
  logic [6:0]           rx_sh;
  logic [1:0]           addr_cnt;
  logic [ADDR_BITS-1:0] data_addr;
  logic                 is_wr, clr_at_end, lock, wel;
  logic [1:0]           bp;
  logic [7:0]           tx_sh;
  logic                 miso_q;

  function automatic logic [ADDR_BITS-1:0] step_addr(input logic [ADDR_BITS-1:0] a);
    return a + 1'b1;
  endfunction

  // Named internal events
  logic [7:0]           rx_byte;
  logic                 bit_tick, byte_done, guard_hit, wr_fire, stat_fire, wel_drop;
  logic [ADDR_BITS+7:0] addr_cat;
  logic [7:0]           status_byte, tx_fresh;

  assign rx_byte     = {rx_sh, mosi_s};
  assign bit_tick    = sclk_rise & cs_sel;
  assign byte_done   = bit_tick & (bit_cnt == 3'd7);
  assign guard_hit   = addr_guarded(24'(data_addr), ADDR_BITS, bp);
  assign wr_fire     = byte_done & (phase == PH_WDATA) & wel & ~guard_hit;
  assign stat_fire   = byte_done & (phase == PH_STAT_WR) & wel & ~lock;
  assign wel_drop    = frame_end & clr_at_end;
  assign addr_cat    = {data_addr, rx_byte};
  assign status_byte = pack_status(lock, bp, wel);
  assign tx_fresh    = (phase == PH_RDATA)   ? rdata :
                       (phase == PH_STAT_RD) ? status_byte : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_OPCODE;
      bit_cnt    <= '0;
      rx_sh      <= '0;
      addr_cnt   <= '0;
      data_addr  <= '0;
      is_wr      <= 1'b0;
      clr_at_end <= 1'b0;
      lock       <= 1'b0;
      bp         <= '0;
      wel        <= 1'b0;
    end else begin
      if (!cs_sel) begin
        phase    <= PH_OPCODE;
        bit_cnt  <= '0;
        addr_cnt <= '0;
      end else if (bit_tick) begin
        bit_cnt <= bit_cnt + 3'd1;
        rx_sh   <= rx_byte[6:0];
        if (bit_cnt == 3'd7) begin
          case (phase)
            PH_OPCODE: begin
              case (rx_byte)
                OP_ARM:     begin wel <= 1'b1; phase <= PH_SKIP; end
                OP_DISARM:  begin wel <= 1'b0; phase <= PH_SKIP; end
                OP_STAT_RD: phase <= PH_STAT_RD;
                OP_STAT_WR: begin phase <= PH_STAT_WR; clr_at_end <= 1'b1; end
                OP_READ:    begin phase <= PH_ADDR; is_wr <= 1'b0; end
                OP_WRITE:   begin phase <= PH_ADDR; is_wr <= 1'b1; clr_at_end <= 1'b1; end
                default:    phase <= PH_SKIP;
              endcase
            end
            PH_ADDR: begin
              data_addr <= addr_cat[ADDR_BITS-1:0];
              addr_cnt  <= addr_cnt + 2'd1;
              if (addr_cnt == 2'd2) phase <= is_wr ? PH_WDATA : PH_RDATA;
            end
            PH_RDATA, PH_WDATA: data_addr <= step_addr(data_addr);
            PH_STAT_WR: begin
              if (stat_fire) begin
                lock <= rx_byte[7];
                bp   <= rx_byte[3:2];
              end
              phase <= PH_SKIP;
            end
            default: ;
          endcase
        end
      end
      if (wel_drop) begin
        wel        <= 1'b0;
        clr_at_end <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      miso_q <= 1'b0;
      tx_sh  <= '0;
    end else if (!cs_sel) begin
      miso_q <= 1'b0;
      tx_sh  <= '0;
    end else if (sclk_fall) begin
      if (bit_cnt == 3'd0) begin
        miso_q <= tx_fresh[7];
        tx_sh  <= {tx_fresh[6:0], 1'b0};
      end else begin
        miso_q <= tx_sh[7];
        tx_sh  <= {tx_sh[6:0], 1'b0};
      end
    end
  end

  assign we       = wr_fire;
  assign mem_addr = data_addr;
  assign wdata    = rx_byte;
  assign miso     = miso_q;

  // R1: reply line quiet while deselected
  p_miso_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_sel |=> !miso);
  // R3: reply line moves only on falling serial edges
  p_miso_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_sel && !sclk_fall) |=> $stable(miso));
  // R5: address steps once per data byte
  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && (phase == PH_RDATA || phase == PH_WDATA))
      |=> data_addr == step_addr($past(data_addr)));
  // R6: arm command sets the latch
  p_wel_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && phase == PH_OPCODE && rx_byte == OP_ARM) |=> wel);
  // R7: array writes only in the data phase with the latch set
  p_we_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (wel && phase == PH_WDATA && cs_sel));
  // R8: latch cleared after a write frame ends
  p_wel_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && clr_at_end) |=> !wel);
  // R9: status lock is sticky and freezes the guard bits
  p_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> (lock && $stable(bp)));
endmodule

// File: rtl/mram_spi_target.sv
module mram_spi_target #(
  parameter int ADDR_BITS   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso
);
  logic                 sclk_rise, sclk_fall, cs_sel, frame_end, mosi_s;
  logic                 we;
  logic [ADDR_BITS-1:0] mem_addr;
  logic [7:0]           wdata, rdata;

  mspi_frontend #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_sel(cs_sel),
    .frame_end(frame_end), .mosi_s(mosi_s));

  mspi_ctrl #(.ADDR_BITS(ADDR_BITS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_sel(cs_sel), .frame_end(frame_end), .mosi_s(mosi_s), .rdata(rdata),
    .we(we), .mem_addr(mem_addr), .wdata(wdata), .miso(spi_miso));

  mspi_array #(.ADDR_BITS(ADDR_BITS)) u_array (
    .clk(clk), .we(we), .addr(mem_addr), .wdata(wdata), .rdata(rdata));
endmodule

// File: tb/mram_spi_target_test.sv
module mram_spi_target_test;
  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;
  localparam int H     = 8;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  always #10 clk = ~clk;

  mram_spi_target #(.ADDR_BITS(AW)) uut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso));

  logic [7:0] mdl [DEPTH];
  bit         known [DEPTH];
  logic       m_wel, m_lock;
  logic [1:0] m_bp;
  int         checks = 0, errors = 0;
  logic [7:0] txb [0:39];
  logic [7:0] rxb [0:39];

  function automatic bit fenced(input int a, input logic [1:0] bp);
    case (bp)
      2'b00:   return 0;
      2'b01:   return a >= (DEPTH * 3) / 4;
      2'b10:   return a >= DEPTH / 2;
      default: return 1;
    endcase
  endfunction

  function automatic logic [7:0] exp_status();
    return {m_lock, 3'b000, m_bp, m_wel, 1'b0};
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input int n);
    cs_n = 1'b0;
    tick(H);
    for (int i = 0; i < n; i++) begin
      for (int b = 7; b >= 0; b--) begin
        mosi = txb[i][b];
        tick(H);
        rxb[i][b] = miso;
        sclk = 1'b1;
        tick(H);
        sclk = 1'b0;
      end
    end
    tick(H);
    cs_n = 1'b1;
    mosi = 1'b0;
    tick(2 * H);
  endtask

  task automatic arm();
    txb[0] = 8'h06; xfer(1); m_wel = 1'b1;
  endtask

  task automatic check_status(input string req);
    txb[0] = 8'h05; txb[1] = 8'h00; xfer(2);
    check(rxb[1] == exp_status(), req, rxb[1], exp_status());
  endtask

  task automatic set_addr(input logic [7:0] op, input int a);
    logic [23:0] a24;
    a24 = {$urandom_range(0, 255) & 8'hFF, 16'h0000} | 24'(a);
    a24[23:AW] = 14'($urandom);
    txb[0] = op; txb[1] = a24[23:16]; txb[2] = a24[15:8]; txb[3] = a24[7:0];
  endtask

  task automatic write_data(input int a, input int len);
    set_addr(8'h02, a);
    for (int i = 0; i < len; i++) txb[4 + i] = 8'($urandom);
    xfer(4 + len);
    for (int i = 0; i < len; i++) begin
      int p;
      p = (a + i) % DEPTH;
      if (m_wel && !fenced(p, m_bp)) begin
        mdl[p] = txb[4 + i];
        known[p] = 1;
      end
    end
    m_wel = 1'b0;
  endtask

  task automatic read_check(input int a, input int len, input string req);
    set_addr(8'h03, a);
    for (int i = 0; i < len; i++) txb[4 + i] = 8'h00;
    xfer(4 + len);
    for (int i = 0; i < len; i++) begin
      int p;
      p = (a + i) % DEPTH;
      if (known[p]) check(rxb[4 + i] == mdl[p], req, rxb[4 + i], mdl[p]);
    end
  endtask

  task automatic write_status(input logic [7:0] v);
    txb[0] = 8'h01; txb[1] = v; xfer(2);
    if (m_wel && !m_lock) begin
      m_lock = v[7];
      m_bp = v[3:2];
    end
    m_wel = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(4);
    rst_n = 1'b1;
    tick(4);
    m_wel = 1'b0; m_lock = 1'b0; m_bp = 2'b00;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd5171));
    for (int i = 0; i < DEPTH; i++) known[i] = 0;
    do_reset();

    // R1: reset state
    check(miso == 1'b0, "R1 miso idle", miso, 0);
    check_status("R1 status after reset");

    // R6 / R2: arm and disarm
    arm();
    check_status("R6 latch set by 0x06");
    txb[0] = 8'h04; xfer(1); m_wel = 1'b0;
    check_status("R6 latch cleared by 0x04");

    // R11: status repeated for every byte
    arm();
    txb[0] = 8'h05; txb[1] = 0; txb[2] = 0; txb[3] = 0; xfer(4);
    for (int i = 1; i < 4; i++)
      check(rxb[i] == exp_status(), "R11 status repeats", rxb[i], exp_status());
    txb[0] = 8'h04; xfer(1); m_wel = 1'b0;

    // R4 / R3: basic write and read back
    arm(); write_data(16, 6);
    check_status("R8 latch cleared after write frame");
    read_check(16, 6, "R4 read back");

    // R7: write without latch is ignored
    write_data(16, 4);
    read_check(16, 6, "R7 unarmed write ignored");

    // R5: wrap at top of array
    arm(); write_data(DEPTH - 2, 4);
    read_check(DEPTH - 2, 4, "R5 wrap to zero");

    // R11: unknown opcode ignores the rest of the frame
    txb[0] = 8'hAB; txb[1] = 8'h06; xfer(2);
    check_status("R11 unknown opcode ignored");

    // R9: status write without latch ignored
    write_status(8'h0C);
    check_status("R9 unarmed status write ignored");

    // R10: guard regions
    arm(); write_data(DEPTH / 2 - 8, 16);
    arm(); write_data((DEPTH * 3) / 4 - 8, 16);
    for (int g = 1; g < 4; g++) begin
      arm(); write_status(8'(g << 2) | 8'h73);
      check_status("R9 status bits written");
      arm(); write_data(DEPTH / 2 - 8, 16);
      read_check(DEPTH / 2 - 8, 16, "R10 guard half boundary");
      arm(); write_data((DEPTH * 3) / 4 - 8, 16);
      read_check((DEPTH * 3) / 4 - 8, 16, "R10 guard quarter boundary");
    end
    arm(); write_status(8'h00);
    check_status("R9 guard cleared");

    // Random mix
    for (int it = 0; it < 30; it++) begin
      int kind, a, len;
      kind = $urandom_range(0, 9);
      a    = $urandom_range(0, DEPTH - 1);
      len  = $urandom_range(1, 6);
      if (kind < 4) begin
        arm(); write_data(a, len);
        read_check(a, len, "R4 random write/read");
      end else if (kind < 6) begin
        write_data(a, len);
        read_check(a, len, "R7 random unarmed write");
      end else if (kind < 8) begin
        read_check(a, len, "R5 random read");
      end else begin
        arm(); write_status(8'($urandom_range(0, 3) << 2));
        check_status("R10 random guard");
      end
    end

    // R9: lock
    arm(); write_status(8'h84);
    check_status("R9 lock set");
    arm(); write_status(8'h08);
    check_status("R9 locked status unchanged");
    arm(); write_data(0, 4);
    read_check(0, 4, "R10 guard holds under lock");
    txb[0] = 8'h04; xfer(1); m_wel = 1'b0;

    // R1: reset clears status but keeps array
    do_reset();
    check_status("R1 status after second reset");
    read_check(16, 6, "R1 array kept over reset");

    finish_run();
  end
endmodule